// File: doc/BRIEF.md
# Line-to-message interrupt redirector

This block turns a set of level-sensitive interrupt wires into addressed write messages. Each input line owns one table entry that holds a target address, a data word and an enable bit. When an enabled line is seen high, the block issues one posted write carrying that entry's address and data on a valid/ready write master port. The receiver can tell which line fired from the message alone, because every line has its own entry.

Once its message has gone out, a line is in service. It sends nothing more until software writes the line's index to the end-of-interrupt register. If the wire is still high at that point, a fresh message follows. Several waiting lines are served one at a time, lowest index first. The register interface is a single-cycle write strobe with a combinational read port. Word addresses are laid out as follows:

- The entry of line i occupies words 4i (address), 4i+1 (data) and 4i+2 (control). In the control word, bit 0 is the enable and writing 1 to bit 1 drops a waiting request.
- Word 4N takes the end-of-interrupt command.
- Word 4N+1 reads back status, with pending in bits [N-1:0] and in-service in bits [2N-1:N].

Top module: `irq_msg_redirector`

## Requirements
- R1: After reset every line is masked, no line is pending or in service, `wr_valid` is low, and every table word and the status word read zero.
- R2: A write to word 4i stores line i's target address and a write to word 4i+1 stores its data. Both read back unchanged at the same word. Control bit 0 at word 4i+2 reads back as written.
- R3: When an enabled, idle line goes high, `wr_valid` rises at the fourth rising clock edge after the input change (two synchroniser flops, one pending flop, one issue flop). `wr_addr` and `wr_data` then carry that line's entry.
- R4: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady. The cycle after a handshake, `wr_valid` is low.
- R5: After its message is issued, a line shows its in-service bit (status bit N+i) and sends no further message while its input stays high.
- R6: Writing a line index to word 4N clears that line's in-service state. A line still high then sends exactly one new message. A line that is low sends none.
- R7: Only one write is outstanding at a time. Lines that are waiting at the same time are sent in ascending index order, and a waiting line shows its pending bit (status bit i).
- R8: A masked line sends no message and never shows pending. Clearing the enable of a pending line discards its pending request.
- R9: Writing a control word with bit 1 set discards the line's pending request, so no message is sent for it if the input has already dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LINES | Asynchronous level interrupt lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+3 | Register word address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, combinational from `reg_addr` |
| wr_valid | output | 1 | Message write request valid |
| wr_ready | input | 1 | Message write accepted |
| wr_addr | output | ADDR_W | Message target address |
| wr_data | output | DATA_W | Message data word |

## Verification
A line change is due at `wr_valid` four rising edges later. The bench drives inputs just after a rising edge and samples at the falling edges after the third and fourth edges, expecting low and then high. Register writes take effect at the single edge inside the write task, and reads are taken combinationally a moment after the address settles. Message counts and orderings are checked only after a window long enough for every handshake. A monitor records each accepted write at the falling edge before the accepting rising edge.

// File: rtl/irq_msg_redirector.sv
module irq_msg_redirector #(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_W = 32,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int RAW = IDX_W + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 reg_we,
  input  logic [RAW-1:0]       reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [DATA_W-1:0]    wr_data
);
  localparam logic [RAW-1:0] EOI_WORD  = RAW'(4 * NUM_LINES);
  localparam logic [RAW-1:0] STAT_WORD = RAW'(4 * NUM_LINES + 1);

  logic [NUM_LINES-1:0] sync1, sync2, enable, pending, in_service;
  logic [NUM_LINES-1:0] en_n, pend_n, serv_n;
  logic [ADDR_W-1:0] tgt_addr [NUM_LINES];
  logic [DATA_W-1:0] tgt_data [NUM_LINES];
  logic [IDX_W-1:0] sel;
  logic sel_hit;

  wire [IDX_W-1:0] reg_line  = reg_addr[IDX_W+1:2];
  wire [1:0]       reg_field = reg_addr[1:0];
  wire             in_table  = reg_addr < EOI_WORD;
  wire             ctrl_wr   = reg_we && in_table && reg_field == 2'd2;
  wire             eoi_wr    = reg_we && reg_addr == EOI_WORD && reg_wdata < REG_W'(NUM_LINES);
  wire [IDX_W-1:0] eoi_line  = reg_wdata[IDX_W-1:0];
  wire [NUM_LINES-1:0] eligible = pending & enable;
  wire             launch    = sel_hit && !wr_valid;

  always_comb begin
    sel = '0;
    sel_hit = 1'b0;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (eligible[i]) begin
        sel = IDX_W'(i);
        sel_hit = 1'b1;
      end
  end

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      en_n[i] = enable[i];
      pend_n[i] = pending[i];
      serv_n[i] = in_service[i];
      if (sync2[i] && enable[i] && !in_service[i]) pend_n[i] = 1'b1;
      if (eoi_wr && eoi_line == IDX_W'(i)) serv_n[i] = 1'b0;
      if (launch && sel == IDX_W'(i)) begin
        pend_n[i] = 1'b0;
        serv_n[i] = 1'b1;
      end
      if (ctrl_wr && reg_line == IDX_W'(i)) begin
        en_n[i] = reg_wdata[0];
        if (!reg_wdata[0] || reg_wdata[1] || !enable[i]) pend_n[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      enable <= '0;
      pending <= '0;
      in_service <= '0;
      wr_valid <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      for (int i = 0; i < NUM_LINES; i++) begin
        tgt_addr[i] <= '0;
        tgt_data[i] <= '0;
      end
    end else begin
      sync1 <= irq_in;
      sync2 <= sync1;
      enable <= en_n;
      pending <= pend_n;
      in_service <= serv_n;
      if (reg_we && in_table && reg_field == 2'd0) tgt_addr[reg_line] <= reg_wdata[ADDR_W-1:0];
      if (reg_we && in_table && reg_field == 2'd1) tgt_data[reg_line] <= reg_wdata[DATA_W-1:0];
      if (launch) begin
        wr_valid <= 1'b1;
        wr_addr <= tgt_addr[sel];
        wr_data <= tgt_data[sel];
      end else if (wr_ready) begin
        wr_valid <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (in_table) begin
      case (reg_field)
        2'd0: reg_rdata = REG_W'(tgt_addr[reg_line]);
        2'd1: reg_rdata = REG_W'(tgt_data[reg_line]);
        2'd2: reg_rdata = REG_W'(enable[reg_line]);
        default: reg_rdata = '0;
      endcase
    end else if (reg_addr == STAT_WORD) begin
      reg_rdata = REG_W'({in_service, pending});
    end
  end

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  assert_drop_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> !wr_valid);
  assert_no_masked_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending & ~enable) == '0);
  assert_pending_excl_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending & in_service) == '0);
  assert_issue_marks_service_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $countones(in_service) > 0);
endmodule

// File: tb/tb_irq_msg_redirector.sv
module tb_irq_msg_redirector;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int EOI = 4 * N;
  localparam int STAT = 4 * N + 1;
  localparam logic [31:0] ABASE = 32'h8000_0000;
  localparam logic [31:0] DBASE = 32'h0000_5A00;
  localparam int NPAT = 6;
  localparam logic [7:0] PATS [NPAT] = '{8'h01, 8'h81, 8'h54, 8'hFF, 8'h60, 8'h0A};

  logic clk = 0, rst_n = 0, reg_we = 0, wr_ready = 0;
  logic [N-1:0] irq_in = '0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, wr_addr, wr_data;
  logic wr_valid;
  int checks = 0, errors = 0, msg_count = 0;
  logic [31:0] msg_addr [256];
  logic [31:0] msg_data [256];

  irq_msg_redirector dut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk)
    if (rst_n && wr_valid && wr_ready && msg_count < 256) begin
      msg_addr[msg_count] = wr_addr;
      msg_data[msg_count] = wr_data;
      msg_count++;
    end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wreg(int a, logic [31:0] d);
    @(posedge clk); #2;
    reg_we = 1; reg_addr = 6'(a); reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 0;
  endtask

  task automatic rreg(int a, output logic [31:0] d);
    reg_addr = 6'(a);
    #1;
    d = reg_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base, k;
    tick(3);
    rst_n = 1;
    tick(1);
    chk("R1 wr_valid", 32'(wr_valid), 0);
    rreg(STAT, v); chk("R1 status", v, 0);
    rreg(2, v); chk("R1 line0 ctrl", v, 0);
    rreg(12, v); chk("R1 line3 addr", v, 0);

    for (int i = 0; i < N; i++) begin
      wreg(4*i, ABASE + 32'(i) * 32'h40);
      wreg(4*i + 1, DBASE + 32'(i));
      wreg(4*i + 2, 32'h1);
    end
    for (int i = 0; i < N; i++) begin
      rreg(4*i, v); chk("R2 addr readback", v, ABASE + 32'(i) * 32'h40);
      rreg(4*i + 1, v); chk("R2 data readback", v, DBASE + 32'(i));
      rreg(4*i + 2, v); chk("R2 ctrl readback", v, 1);
    end

    wr_ready = 1;
    for (int p = 0; p < NPAT; p++) begin
      base = msg_count;
      irq_in = PATS[p];
      tick(40);
      chk("R7 message count", 32'(msg_count - base), 32'($countones(PATS[p])));
      k = 0;
      for (int i = 0; i < N; i++)
        if (PATS[p][i]) begin
          chk("R7 ascending order", msg_data[base + k], DBASE + 32'(i));
          chk("R3 message address", msg_addr[base + k], ABASE + 32'(i) * 32'h40);
          k++;
        end
      irq_in = '0;
      tick(4);
      for (int i = 0; i < N; i++) wreg(EOI, 32'(i));
      tick(4);
      rreg(STAT, v); chk("R6 status idle after EOI", v, 0);
    end

    base = msg_count;
    @(posedge clk); #2;
    irq_in[2] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R3 not yet valid at edge 3", 32'(wr_valid), 0);
    @(posedge clk); @(negedge clk);
    chk("R3 valid at edge 4", 32'(wr_valid), 1);
    chk("R3 data line2", wr_data, DBASE + 32'd2);
    tick(20);
    chk("R5 single message while high", 32'(msg_count - base), 1);
    rreg(STAT, v); chk("R5 in-service bit", v, 32'h1 << (N + 2));
    wreg(EOI, 32'd2);
    tick(12);
    chk("R6 re-message after EOI", 32'(msg_count - base), 2);
    irq_in[2] = 0;
    tick(5);
    wreg(EOI, 32'd2);
    tick(12);
    chk("R6 no message when low", 32'(msg_count - base), 2);
    rreg(STAT, v); chk("R6 status clear", v, 0);

    wr_ready = 0;
    base = msg_count;
    irq_in[5] = 1;
    tick(8);
    chk("R4 held valid", 32'(wr_valid), 1);
    chk("R4 held addr", wr_addr, ABASE + 32'd5 * 32'h40);
    irq_in[1] = 1;
    tick(8);
    chk("R4 still line5 data", wr_data, DBASE + 32'd5);
    rreg(STAT, v); chk("R7 line1 waiting", v, (32'h1 << 1) | (32'h1 << (N + 5)));
    wr_ready = 1;
    tick(10);
    chk("R7 two messages", 32'(msg_count - base), 2);
    chk("R7 line1 second", msg_data[base + 1], DBASE + 32'd1);
    irq_in = '0;
    tick(4);
    wreg(EOI, 32'd5); wreg(EOI, 32'd1);

    wr_ready = 0;
    base = msg_count;
    irq_in[0] = 1;
    tick(8);
    irq_in[6] = 1;
    tick(6);
    irq_in[6] = 0;
    tick(4);
    rreg(STAT, v); chk("R9 line6 pending", v & 32'h40, 32'h40);
    wreg(26, 32'h3);
    rreg(STAT, v); chk("R9 pending dropped", v & 32'h40, 0);
    irq_in[7] = 1;
    tick(6);
    irq_in[7] = 0;
    tick(4);
    rreg(STAT, v); chk("R8 line7 pending", v & 32'h80, 32'h80);
    wreg(30, 32'h0);
    rreg(STAT, v); chk("R8 disable drops pending", v & 32'h80, 0);
    wr_ready = 1;
    tick(12);
    chk("R9 only line0 sent", 32'(msg_count - base), 1);
    irq_in[0] = 0;
    tick(4);
    wreg(EOI, 32'd0);
    base = msg_count;
    irq_in[7] = 1;
    tick(15);
    chk("R8 masked line silent", 32'(msg_count - base), 0);
    rreg(STAT, v); chk("R8 masked no pending", v, 0);
    irq_in[7] = 0;
    tick(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule